// File: doc/BRIEF.md
# Shared-Prescaler Timer and Watchdog

This block pairs an 8-bit timer/counter with a watchdog counter. A single binary prescaler sits between them. Software assigns the prescaler to one side or the other through an option register. The timer advances on the internal instruction-cycle tick, or on one chosen edge of an external pin. That pin is passed through a two-flop synchroniser before any edge is detected. When the timer wraps from FFh to 00h it raises an interrupt flag, and the flag stays set until software clears it.

The watchdog advances on a free-running tick input. A clear-watchdog strobe or a sleep command restarts it. If neither arrives in time, the watchdog issues a one-cycle reset request and drops an active-low time-out status bit. One 3-bit code selects the division ratio, and the result depends on which side owns the prescaler. On the timer side, code n divides by 2^(n+1), so the range is 2 to 256. On the watchdog side, code n divides by 2^n, so the range is 1 to 128. Whichever side does not own the prescaler counts its own events undivided.

Top module: `shared_prescale_timer`

## Requirements
- R1: After reset, `opt_q` is FFh, `tmr_q` is 00h, `tmr_flag` is 0, `wdt_to_n` is 1 and `wdt_rst_req` is 0.
- R2: A write to `opt_wdata` appears on `opt_q` on the next cycle. The fields are:
  - bit 3: prescaler owner (1 = watchdog, 0 = timer)
  - bit 5: timer source (0 = `icyc_tick`, 1 = external pin)
  - bit 4: pin edge (0 = rising, 1 = falling)
  - bits 2:0: ratio code
- R3: With the timer source set to `icyc_tick` and the prescaler owned by the watchdog, `tmr_q` increases by exactly one for every cycle in which `icyc_tick` is high.
- R4: With the prescaler owned by the timer and ratio code n, `tmr_q` increases once per 2^(n+1) source events. The first increase comes on event number 2^(n+1) after the prescaler was last cleared.
- R5: With bit 5 set, only the edge of `ext_pin` chosen by bit 4 is counted, and `icyc_tick` is ignored. A counted pin change shows on `tmr_q` after the third rising clock edge following it.
- R6: A timer increment from FFh to 00h sets `tmr_flag`. The flag stays set until a `flag_clr` pulse. If a wrap and `flag_clr` fall in the same cycle, the flag ends up set.
- R7: A timer write loads `tmr_wdata` on the next cycle. It takes precedence over an increment in the same cycle, and it clears the prescaler count.
- R8: An option write that changes the prescaler owner clears the prescaler count.
- R9: With the prescaler owned by the watchdog and ratio code n, the watchdog times out on watchdog tick number 2^n * 2^WDT_W after its last clear. A time-out gives `wdt_rst_req` high for exactly one cycle and drives `wdt_to_n` to 0.
- R10: `wdt_clr` or `sleep_cmd` restarts the watchdog count, sets `wdt_to_n` to 1, and clears the prescaler when the watchdog owns it. A clear in the same cycle as a time-out suppresses the time-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_wr | input | 1 | Option register write strobe |
| opt_wdata | input | 8 | Option register write data |
| opt_q | output | 8 | Option register contents |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write data |
| tmr_q | output | 8 | Timer count |
| icyc_tick | input | 1 | Internal instruction-cycle tick |
| ext_pin | input | 1 | Asynchronous external count pin |
| tmr_flag | output | 1 | Timer wrap interrupt flag |
| flag_clr | input | 1 | Software clear of the wrap flag |
| wdt_tick | input | 1 | Free-running watchdog tick |
| wdt_clr | input | 1 | Clear-watchdog strobe |
| sleep_cmd | input | 1 | Sleep command, also restarts the watchdog |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request |
| wdt_to_n | output | 1 | Time-out status, 0 after a time-out |

## Verification
Several pairs of actions can land in the same clock cycle, and the bench drives each pair together on purpose:
- a timer wrap together with a software flag clear;
- a timer increment together with a timer write;
- a watchdog time-out together with a clear-watchdog strobe.

In every case the ports are checked on the following cycle. The expected results are: the flag is still set, the written value is loaded exactly with no increment added, and neither a reset request nor a dropped status bit appears. Prescaler clears are judged by tick counts alone. The bench places residual prescaler counts so that a missing clear would move the next timer increment to a visibly earlier tick.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int CODE_W = 3;

  typedef struct packed {
    logic [1:0]        spare;
    logic              src_ext;
    logic              fall_edge;
    logic              to_wdt;
    logic [CODE_W-1:0] code;
  } opt_t;

  localparam opt_t OPT_RESET = '{spare: 2'b11, src_ext: 1'b1, fall_edge: 1'b1,
                                 to_wdt: 1'b1, code: '1};
endpackage

// File: rtl/tps_pin_edge.sv
module tps_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  input  logic fall_sel,
  output logic edge_evt
);
  logic [SYNC_STAGES:0] sh_q, sh_d;
  logic cur, prev;

  always_comb begin
    sh_d = {sh_q[SYNC_STAGES-1:0], pin_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign cur      = sh_q[SYNC_STAGES-1];
  assign prev     = sh_q[SYNC_STAGES];
  assign edge_evt = fall_sel ? (prev & ~cur) : (cur & ~prev);

  // R5: a reported edge is a real level change of the synchronised pin
  assert_edge_is_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> (sh_q[SYNC_STAGES] != $past(sh_q[SYNC_STAGES])));
endmodule

// File: rtl/tps_prescaler.sv
module tps_prescaler #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              evt_in,
  input  logic              to_wdt,
  input  logic [CODE_W-1:0] code,
  output logic              evt_out
);
  localparam int PS_W = 1 << CODE_W;

  logic [PS_W-1:0] cnt_q, cnt_d, mask;
  logic [CODE_W:0] expo;
  logic            fire;

  always_comb begin
    expo = to_wdt ? {1'b0, code} : ({1'b0, code} + 1'b1);
    for (int i = 0; i < PS_W; i++) mask[i] = (i < int'(expo));
  end

  assign fire    = evt_in & (&(cnt_q | ~mask));
  assign evt_out = fire & ~clr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (evt_in) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7 / R8: every clear request empties the prescaler
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  // R4: an output event only follows an input event
  assert_out_needs_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_out |-> evt_in);
endmodule

// File: rtl/tps_timer8.sv
module tps_timer8 #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             wr,
  input  logic [TMR_W-1:0] wdata,
  input  logic             flag_clr,
  output logic [TMR_W-1:0] cnt,
  output logic             flag
);
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d, wrap;

  assign wrap = inc & ~wr & (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (wr)       cnt_d = wdata;
    else if (inc) cnt_d = cnt_q + 1'b1;
    flag_d = flag_q;
    if (wrap)          flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;

  assert_write_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cnt_q == $past(wdata)));
  assert_flag_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(cnt_q) == '1 && cnt_q == '0));
endmodule

// File: rtl/tps_watchdog.sv
module tps_watchdog #(
  parameter int WDT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic rst_req,
  output logic to_n
);
  logic [WDT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d, ton_q, ton_d, timeout;

  assign timeout = evt & ~clr & (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (clr || timeout) cnt_d = '0;
    else if (evt)       cnt_d = cnt_q + 1'b1;
    req_d = timeout;
    ton_d = ton_q;
    if (clr)          ton_d = 1'b1;
    else if (timeout) ton_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
      ton_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
      ton_q <= ton_d;
    end
  end

  assign rst_req = req_q;
  assign to_n    = ton_q;

  assert_req_drops_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !to_n);
  assert_req_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_clear_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && to_n && !rst_req));
endmodule

// File: rtl/shared_prescale_timer.sv
module shared_prescale_timer
  import tps_pkg::*;
#(
  parameter int TMR_W       = 8,
  parameter int WDT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opt_wr,
  input  logic [7:0]       opt_wdata,
  output logic [7:0]       opt_q,
  input  logic             tmr_wr,
  input  logic [TMR_W-1:0] tmr_wdata,
  output logic [TMR_W-1:0] tmr_q,
  input  logic             icyc_tick,
  input  logic             ext_pin,
  output logic             tmr_flag,
  input  logic             flag_clr,
  input  logic             wdt_tick,
  input  logic             wdt_clr,
  input  logic             sleep_cmd,
  output logic             wdt_rst_req,
  output logic             wdt_to_n
);
  opt_t opt_r, opt_d, opt_new;
  logic pin_evt, src_evt, ps_in, ps_out, ps_clr;
  logic tmr_evt, wdt_evt, wdt_restart, owner_change;

  assign opt_new = opt_t'(opt_wdata);

  always_comb begin
    opt_d = opt_r;
    if (opt_wr) opt_d = opt_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) opt_r <= OPT_RESET;
    else        opt_r <= opt_d;
  end

  assign opt_q = opt_r;

  tps_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_async(ext_pin),
    .fall_sel(opt_r.fall_edge), .edge_evt(pin_evt));

  assign src_evt      = opt_r.src_ext ? pin_evt : icyc_tick;
  assign wdt_restart  = wdt_clr | sleep_cmd;
  assign owner_change = opt_wr & (opt_new.to_wdt != opt_r.to_wdt);
  assign ps_in        = opt_r.to_wdt ? wdt_tick : src_evt;
  assign ps_clr       = tmr_wr | owner_change | (opt_r.to_wdt & wdt_restart);

  tps_prescaler #(.CODE_W(CODE_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .clr(ps_clr), .evt_in(ps_in),
    .to_wdt(opt_r.to_wdt), .code(opt_r.code), .evt_out(ps_out));

  assign tmr_evt = opt_r.to_wdt ? src_evt : ps_out;
  assign wdt_evt = opt_r.to_wdt ? ps_out  : wdt_tick;

  tps_timer8 #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .inc(tmr_evt), .wr(tmr_wr), .wdata(tmr_wdata),
    .flag_clr(flag_clr), .cnt(tmr_q), .flag(tmr_flag));

  tps_watchdog #(.WDT_W(WDT_W)) u_wdt (
    .clk(clk), .rst_n(rst_n), .evt(wdt_evt), .clr(wdt_restart),
    .rst_req(wdt_rst_req), .to_n(wdt_to_n));

  assert_opt_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    opt_wr |=> (opt_q == $past(opt_wdata)));
  assert_ext_ignores_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_r.src_ext && opt_r.to_wdt && !pin_evt && !tmr_wr) |=> $stable(tmr_q));
endmodule

// File: tb/test_shared_prescale_timer.sv
module test_shared_prescale_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic opt_wr = 0, tmr_wr = 0, icyc_tick = 0, ext_pin = 0, flag_clr = 0;
  logic wdt_tick = 0, wdt_clr = 0, sleep_cmd = 0;
  logic [7:0] opt_wdata = 0, tmr_wdata = 0, opt_q, tmr_q;
  logic tmr_flag, wdt_rst_req, wdt_to_n;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  shared_prescale_timer i_shared_prescale_timer (
    .clk(clk), .rst_n(rst_n), .opt_wr(opt_wr), .opt_wdata(opt_wdata), .opt_q(opt_q),
    .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata), .tmr_q(tmr_q), .icyc_tick(icyc_tick),
    .ext_pin(ext_pin), .tmr_flag(tmr_flag), .flag_clr(flag_clr), .wdt_tick(wdt_tick),
    .wdt_clr(wdt_clr), .sleep_cmd(sleep_cmd), .wdt_rst_req(wdt_rst_req),
    .wdt_to_n(wdt_to_n));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_opt(input logic [7:0] v);
    opt_wr = 1; opt_wdata = v; cyc(1); opt_wr = 0;
  endtask

  task automatic put_tmr(input logic [7:0] v);
    tmr_wr = 1; tmr_wdata = v; cyc(1); tmr_wr = 0;
  endtask

  task automatic icyc_run(input int n);
    icyc_tick = 1; cyc(n); icyc_tick = 0;
  endtask

  task automatic wdt_restart_pulse();
    wdt_clr = 1; cyc(1); wdt_clr = 0;
  endtask

  task automatic t_reset();
    check("R1 opt", opt_q, 8'hFF);
    check("R1 tmr", tmr_q, 0);
    check("R1 flag", tmr_flag, 0);
    check("R1 to_n", wdt_to_n, 1);
    check("R1 req", wdt_rst_req, 0);
  endtask

  task automatic t_internal();
    put_opt(8'h08);
    check("R2 opt readback", opt_q, 8'h08);
    put_tmr(8'h00);
    icyc_run(10);
    check("R3 ten ticks", tmr_q, 10);
    icyc_tick = 1; cyc(1); icyc_tick = 0; cyc(1);
    icyc_tick = 1; cyc(1); icyc_tick = 0; cyc(1);
    icyc_tick = 1; cyc(1); icyc_tick = 0;
    check("R3 sparse ticks", tmr_q, 13);
  endtask

  task automatic t_ratio();
    put_opt(8'h00); put_tmr(8'h00);
    icyc_run(7);
    check("R4 ratio 2", tmr_q, 3);
    put_opt(8'h02); put_tmr(8'h00);
    icyc_run(31);
    check("R4 ratio 8 before", tmr_q, 3);
    icyc_run(1);
    check("R4 ratio 8 at", tmr_q, 4);
  endtask

  task automatic t_owner_change();
    put_tmr(8'h00);
    icyc_run(5);
    put_opt(8'h0A); put_opt(8'h02);
    icyc_run(7);
    check("R8 residue cleared", tmr_q, 0);
    icyc_run(1);
    check("R8 first after clear", tmr_q, 1);
  endtask

  task automatic t_write();
    put_tmr(8'h00);
    icyc_run(5);
    put_tmr(8'h10);
    icyc_run(7);
    check("R7 write clears prescaler", tmr_q, 8'h10);
    icyc_run(1);
    check("R7 next increment", tmr_q, 8'h11);
    put_opt(8'h08);
    tmr_wr = 1; tmr_wdata = 8'h40; icyc_tick = 1; cyc(1);
    tmr_wr = 0; icyc_tick = 0;
    check("R7 write beats increment", tmr_q, 8'h40);
  endtask

  task automatic t_overflow();
    put_tmr(8'hFD);
    icyc_run(2);
    check("R6 at FF", tmr_q, 8'hFF);
    check("R6 no flag yet", tmr_flag, 0);
    icyc_run(1);
    check("R6 wrapped", tmr_q, 8'h00);
    check("R6 flag set", tmr_flag, 1);
    icyc_run(3);
    check("R6 flag held", tmr_flag, 1);
    flag_clr = 1; cyc(1); flag_clr = 0;
    check("R6 flag cleared", tmr_flag, 0);
    put_tmr(8'hFF);
    icyc_tick = 1; flag_clr = 1; cyc(1); icyc_tick = 0; flag_clr = 0;
    check("R6 set beats clear", tmr_flag, 1);
    flag_clr = 1; cyc(1); flag_clr = 0;
  endtask

  task automatic t_pin();
    put_opt(8'h28); put_tmr(8'h00);
    icyc_tick = 1;
    ext_pin = 1; cyc(2);
    check("R5 not yet", tmr_q, 0);
    cyc(1);
    check("R5 rising counted", tmr_q, 1);
    ext_pin = 0; cyc(4);
    check("R5 falling ignored", tmr_q, 1);
    put_opt(8'h38);
    ext_pin = 1; cyc(4);
    check("R5 rising ignored", tmr_q, 1);
    ext_pin = 0; cyc(4);
    check("R5 falling counted", tmr_q, 2);
    icyc_tick = 0;
  endtask

  task automatic t_watchdog();
    put_opt(8'h08);
    wdt_restart_pulse();
    wdt_tick = 1; cyc(255);
    check("R9 no early req", wdt_rst_req, 0);
    cyc(1);
    check("R9 req", wdt_rst_req, 1);
    check("R9 status low", wdt_to_n, 0);
    wdt_tick = 0; cyc(1);
    check("R9 req one cycle", wdt_rst_req, 0);
    put_opt(8'h09);
    wdt_restart_pulse();
    check("R10 status set", wdt_to_n, 1);
    wdt_tick = 1; cyc(511);
    check("R9 ratio 2 early", wdt_rst_req, 0);
    cyc(1); wdt_tick = 0;
    check("R9 ratio 2 req", wdt_rst_req, 1);
  endtask

  task automatic t_restart();
    put_opt(8'h08);
    wdt_restart_pulse();
    wdt_tick = 1; cyc(200); wdt_tick = 0;
    sleep_cmd = 1; cyc(1); sleep_cmd = 0;
    wdt_tick = 1; cyc(255);
    check("R10 sleep restarted", wdt_rst_req, 0);
    cyc(1); wdt_tick = 0;
    check("R10 timeout after sleep", wdt_rst_req, 1);
    wdt_restart_pulse();
    wdt_tick = 1; cyc(255);
    wdt_clr = 1; cyc(1); wdt_clr = 0;
    check("R10 clear beats timeout req", wdt_rst_req, 0);
    check("R10 clear beats timeout status", wdt_to_n, 1);
    cyc(255);
    check("R10 count restarted", wdt_rst_req, 0);
    cyc(1); wdt_tick = 0;
    check("R10 later timeout", wdt_rst_req, 1);
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    t_reset();
    t_internal();
    t_ratio();
    t_owner_change();
    t_write();
    t_overflow();
    t_pin();
    t_watchdog();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule